// File: doc/BRIEF.md
# Address Translation Route Selector

This block sits in front of a page-based translation lookaside buffer and decides, for every address request, which of three routes produces the physical address. When translation is switched off in the global configuration word, the address passes through unchanged with read, write and execute all granted. When a privileged (non-user) request falls into one of the sixteen 256 MB regions marked as direct-mapped, the physical address is built from a 4-bit per-region base and the low 28 address bits, again with full permissions. Every other request is forwarded to the page TLB, and the TLB's answer is returned.

Requests are accepted one per cycle with `req_valid`. The forwarding to the TLB is combinational in the request cycle, and the TLB is expected to answer in that same cycle; the selected result is registered, so the response appears on the `rsp_*` ports one clock after the request. While a request is forwarded, the block tells the TLB whether the instruction-side or the data-side translation structure is to be used.

Top module: `xlate_route`

## Requirements
- R1: Translation is on when bit 3 or bit 2 of `gc_cfg` is set (either one alone suffices); the other bits of `gc_cfg` have no effect on the route.
- R2: With translation off, the response has `rsp_paddr` equal to the request address, `rsp_perm` = 3'b111, `rsp_fault` = 0, `rsp_path` = 0 (bypass), and no TLB request is raised.
- R3: The region number is address bits 31:28; with translation on, a non-user request is direct-mapped when `mm_cfg` bit [region] is 1, and goes to the TLB when that bit is 0.
- R4: A user request (`req_user` = 1) with translation on always goes to the TLB, whatever `mm_cfg` says.
- R5: A direct-mapped response has `rsp_paddr` = {base, address bits 27:0}, `rsp_perm` = 3'b111, `rsp_fault` = 0, `rsp_path` = 1 (region).
- R6: The base for regions 0 to 7 is `kbase_lo` bits [4r+3:4r]; for regions 8 to 15 it is `kbase_hi` bits [4(r-8)+3:4(r-8)].
- R7: A TLB-routed request raises `tlb_req_valid` in the request cycle with `tlb_vaddr`, `tlb_acc` and `tlb_user` equal to the request, and the response carries `tlb_paddr`, `tlb_perm` and `tlb_fault` with `rsp_path` = 2 (paged).
- R8: Access codes are 0 read, 1 write, 2 execute; while `tlb_req_valid` is high, `tlb_sel_insn` is 1 for execute and 0 for read and write.
- R9: `rsp_valid` is 0 after reset and is high exactly in the cycle after a cycle with `req_valid` high; permission bits are ordered {read, write, execute}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for a user-mode request |
| gc_cfg | input | 32 | Global configuration word (bits 3:2 enable translation) |
| mm_cfg | input | 32 | Per-region direct-map enables in bits 15:0 |
| kbase_lo | input | 32 | Packed bases for regions 0 to 7 |
| kbase_hi | input | 32 | Packed bases for regions 8 to 15 |
| tlb_req_valid | output | 1 | Request forwarded to the TLB |
| tlb_vaddr | output | 32 | Address forwarded to the TLB |
| tlb_acc | output | 2 | Access type forwarded to the TLB |
| tlb_user | output | 1 | User flag forwarded to the TLB |
| tlb_sel_insn | output | 1 | 1 selects the instruction-side TLB, 0 the data-side |
| tlb_paddr | input | 32 | TLB physical address answer |
| tlb_perm | input | 3 | TLB permissions {read, write, execute} |
| tlb_fault | input | 1 | TLB fault flag |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted permissions {read, write, execute} |
| rsp_fault | output | 1 | Fault flag |
| rsp_path | output | 2 | Route taken: 0 bypass, 1 region, 2 paged |

## Verification
The route decision is exercised with the enable bits set singly, together and cleared while unrelated configuration bits toggle, which separates a correct two-bit enable test from one that looks at a single bit or the whole word. Regions at both ends of each packed base register (0, 7, 8, 15) with distinct nibbles reveal a wrong register choice or nibble offset. The same direct-mapped region is hit by user and privileged requests, and neighbouring regions with their enable bit cleared, so a missing user check or a shifted enable index shows up. Read, write and execute requests sent to the TLB, back to back and with idle gaps, tell apart the instruction/data selection and the one-cycle response timing.

// File: rtl/xlate_route_pkg.sv
package xlate_route_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      PATH_BYPASS  = 2'd0,
      PATH_SEGMENT = 2'd1,
      PATH_PAGED   = 2'd2
   } path_e;

   localparam int PERM_W = 3;
   localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/xlate_seg_decode.sv
module xlate_seg_decode #(
   parameter int ADDR_W = 32,
   parameter int SEG_W  = 4,
   parameter int CFG_W  = 32
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [CFG_W-1:0]  mm_cfg,
   input  logic [ADDR_W-1:0] base_lo,
   input  logic [ADDR_W-1:0] base_hi,
   output logic              seg_direct,
   output logic [SEG_W-1:0]  base_nib
);

   localparam int NUM_SEG   = 1 << SEG_W;
   localparam int PER_REG   = NUM_SEG / 2;
   localparam int CFG_IDX_W = $clog2(CFG_W);

   if (PER_REG * SEG_W != ADDR_W) begin : g_bad_pack
      $error("base registers must hold exactly half of the region bases");
   end
   if (NUM_SEG > CFG_W) begin : g_bad_cfg
      $error("configuration word too narrow for the region enables");
   end

   logic [SEG_W-1:0]     seg;
   logic [CFG_IDX_W-1:0] cfg_idx;
   logic [SEG_W-1:0]     nib_tab [NUM_SEG];

   assign seg     = vaddr[ADDR_W-1 -: SEG_W];
   assign cfg_idx = CFG_IDX_W'(seg);

   for (genvar s = 0; s < PER_REG; s++) begin : g_nib
      assign nib_tab[s]           = base_lo[s*SEG_W +: SEG_W];
      assign nib_tab[s + PER_REG] = base_hi[s*SEG_W +: SEG_W];
   end

   assign seg_direct = mm_cfg[cfg_idx];
   assign base_nib   = nib_tab[seg];

endmodule

// File: rtl/xlate_path_sel.sv
module xlate_path_sel
   import xlate_route_pkg::*;
#(
   parameter int          CFG_W   = 32,
   parameter logic [31:0] EN_MASK = 32'h0000_000C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_user,
   input  logic [1:0]       req_acc,
   input  logic [CFG_W-1:0] gc_cfg,
   input  logic             seg_direct,
   output logic             mmu_on,
   output path_e            path,
   output logic             tlb_req_valid,
   output logic             tlb_sel_insn
);

   localparam logic [CFG_W-1:0] MASK = CFG_W'(EN_MASK);

   if (MASK == '0) begin : g_bad_mask
      $error("enable mask selects no configuration bit");
   end

   assign mmu_on = |(gc_cfg & MASK);

   always_comb begin
      if (!mmu_on)
         path = PATH_BYPASS;
      else if (!req_user && seg_direct)
         path = PATH_SEGMENT;
      else
         path = PATH_PAGED;
   end

   assign tlb_req_valid = req_valid && (path == PATH_PAGED);
   assign tlb_sel_insn  = (acc_e'(req_acc) == ACC_EXEC);

   assert_user_paged_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user && mmu_on) |-> tlb_req_valid);

   assert_tlb_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |-> (req_valid && mmu_on));

   assert_off_no_tlb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mmu_on |-> !tlb_req_valid);

endmodule

// File: rtl/xlate_resp_reg.sv
module xlate_resp_reg
   import xlate_route_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SEG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  path_e             path,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [SEG_W-1:0]  base_nib,
   input  logic [ADDR_W-1:0] tlb_paddr,
   input  logic [PERM_W-1:0] tlb_perm,
   input  logic              tlb_fault,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              rsp_fault,
   output logic [1:0]        rsp_path
);

   localparam int OFF_W = ADDR_W - SEG_W;

   logic [ADDR_W-1:0] nxt_paddr;
   logic [PERM_W-1:0] nxt_perm;
   logic              nxt_fault;

   always_comb begin
      unique case (path)
         PATH_SEGMENT: begin
            nxt_paddr = {base_nib, vaddr[OFF_W-1:0]};
            nxt_perm  = PERM_ALL;
            nxt_fault = 1'b0;
         end
         PATH_PAGED: begin
            nxt_paddr = tlb_paddr;
            nxt_perm  = tlb_perm;
            nxt_fault = tlb_fault;
         end
         default: begin
            nxt_paddr = vaddr;
            nxt_perm  = PERM_ALL;
            nxt_fault = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_perm  <= '0;
         rsp_fault <= 1'b0;
         rsp_path  <= PATH_BYPASS;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_paddr <= nxt_paddr;
            rsp_perm  <= nxt_perm;
            rsp_fault <= nxt_fault;
            rsp_path  <= path;
         end
      end
   end

   assert_bypass_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path == PATH_BYPASS) |-> (rsp_paddr == $past(vaddr)));

   assert_segment_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path == PATH_SEGMENT) |->
         (rsp_perm == PERM_ALL && !rsp_fault
          && rsp_paddr[OFF_W-1:0] == $past(vaddr[OFF_W-1:0])));

   assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid) |-> rsp_valid);

   assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> !rsp_valid);

endmodule

// File: rtl/xlate_route.sv
module xlate_route
   import xlate_route_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int          SEG_W   = 4,
   parameter int          CFG_W   = 32,
   parameter logic [31:0] EN_MASK = 32'h0000_000C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_acc,
   input  logic              req_user,
   input  logic [CFG_W-1:0]  gc_cfg,
   input  logic [CFG_W-1:0]  mm_cfg,
   input  logic [ADDR_W-1:0] kbase_lo,
   input  logic [ADDR_W-1:0] kbase_hi,
   output logic              tlb_req_valid,
   output logic [ADDR_W-1:0] tlb_vaddr,
   output logic [1:0]        tlb_acc,
   output logic              tlb_user,
   output logic              tlb_sel_insn,
   input  logic [ADDR_W-1:0] tlb_paddr,
   input  logic [2:0]        tlb_perm,
   input  logic              tlb_fault,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [2:0]        rsp_perm,
   output logic              rsp_fault,
   output logic [1:0]        rsp_path
);

   logic             seg_direct;
   logic [SEG_W-1:0] base_nib;
   logic             mmu_on;
   path_e            path;

   xlate_seg_decode #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .CFG_W(CFG_W)) u_seg (
      .vaddr      (req_vaddr),
      .mm_cfg     (mm_cfg),
      .base_lo    (kbase_lo),
      .base_hi    (kbase_hi),
      .seg_direct (seg_direct),
      .base_nib   (base_nib)
   );

   xlate_path_sel #(.CFG_W(CFG_W), .EN_MASK(EN_MASK)) u_sel (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_user      (req_user),
      .req_acc       (req_acc),
      .gc_cfg        (gc_cfg),
      .seg_direct    (seg_direct),
      .mmu_on        (mmu_on),
      .path          (path),
      .tlb_req_valid (tlb_req_valid),
      .tlb_sel_insn  (tlb_sel_insn)
   );

   assign tlb_vaddr = req_vaddr;
   assign tlb_acc   = req_acc;
   assign tlb_user  = req_user;

   xlate_resp_reg #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .path      (path),
      .vaddr     (req_vaddr),
      .base_nib  (base_nib),
      .tlb_paddr (tlb_paddr),
      .tlb_perm  (tlb_perm),
      .tlb_fault (tlb_fault),
      .rsp_valid (rsp_valid),
      .rsp_paddr (rsp_paddr),
      .rsp_perm  (rsp_perm),
      .rsp_fault (rsp_fault),
      .rsp_path  (rsp_path)
   );

   assert_insn_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_req_valid && tlb_acc != 2'd2) |-> !tlb_sel_insn);

   assert_paged_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |=> (rsp_valid && rsp_path == 2'd2 && rsp_paddr == $past(tlb_paddr)));

endmodule

// File: tb/xlate_route_tb_top.sv
`timescale 1ns/1ps
module xlate_route_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [31:0] gc_cfg = '0;
   logic [31:0] mm_cfg = '0;
   logic [31:0] kbase_lo = 32'h7E3C_A950;
   logic [31:0] kbase_hi = 32'h1D6B_2F84;
   logic        tlb_req_valid;
   logic [31:0] tlb_vaddr;
   logic [1:0]  tlb_acc;
   logic        tlb_user;
   logic        tlb_sel_insn;
   logic [31:0] tlb_paddr;
   logic [2:0]  tlb_perm;
   logic        tlb_fault;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_perm;
   logic        rsp_fault;
   logic [1:0]  rsp_path;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_tag = "R9";

   always #10 clk = ~clk;

   // simple TLB responder
   assign tlb_paddr = {~tlb_vaddr[31:12], tlb_vaddr[11:0]};
   assign tlb_perm  = tlb_sel_insn ? 3'b101 : 3'b110;
   assign tlb_fault = tlb_user & tlb_vaddr[4];

   xlate_route dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_user(req_user), .gc_cfg(gc_cfg), .mm_cfg(mm_cfg),
      .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .tlb_req_valid(tlb_req_valid),
      .tlb_vaddr(tlb_vaddr), .tlb_acc(tlb_acc), .tlb_user(tlb_user),
      .tlb_sel_insn(tlb_sel_insn), .tlb_paddr(tlb_paddr), .tlb_perm(tlb_perm),
      .tlb_fault(tlb_fault), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_path(rsp_path)
   );

   task automatic check(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: route for given inputs
   function automatic int route(logic [31:0] gc, logic [31:0] mm, logic [31:0] va, logic usr);
      int seg;
      seg = int'(va >> 28);
      if (gc[3] == 1'b0 && gc[2] == 1'b0) return 0;
      if (!usr && mm[seg]) return 1;
      return 2;
   endfunction

   function automatic logic [3:0] base_of(int seg);
      logic [31:0] r;
      r = (seg < 8) ? kbase_lo : kbase_hi;
      return 4'((r >> (4 * (seg % 8))) & 32'hF);
   endfunction

   // model pipeline, captured at each rising edge
   logic        m_valid = 1'b0;
   logic [31:0] m_paddr;
   logic [2:0]  m_perm;
   logic        m_fault;
   int          m_path;
   string       m_tag = "R9";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 1'b0;
      end else begin
         m_valid = req_valid;
         if (req_valid) begin
            m_tag  = cur_tag;
            m_path = route(gc_cfg, mm_cfg, req_vaddr, req_user);
            case (m_path)
               0: begin m_paddr = req_vaddr; m_perm = 3'b111; m_fault = 1'b0; end
               1: begin
                  m_paddr = {base_of(int'(req_vaddr >> 28)), req_vaddr[27:0]};
                  m_perm = 3'b111; m_fault = 1'b0;
               end
               default: begin
                  m_paddr = {~req_vaddr[31:12], req_vaddr[11:0]};
                  m_perm  = (req_acc == 2'd2) ? 3'b101 : 3'b110;
                  m_fault = req_user & req_vaddr[4];
               end
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R9", "rsp_valid", rsp_valid, m_valid);
         if (m_valid) begin
            check(m_tag, "rsp_path", rsp_path, m_path);
            check(m_tag, "rsp_paddr", rsp_paddr, m_paddr);
            check(m_tag, "rsp_perm", rsp_perm, m_perm);
            check(m_tag, "rsp_fault", rsp_fault, m_fault);
         end
      end
   end

   // drive one request at a falling edge; check the TLB side combinationally
   task automatic req(string tag, logic [31:0] va, logic [1:0] acc, logic usr,
                      logic [31:0] gc, logic [31:0] mm);
      int r;
      @(negedge clk);
      cur_tag   = tag;
      req_valid = 1'b1;
      req_vaddr = va;
      req_acc   = acc;
      req_user  = usr;
      gc_cfg    = gc;
      mm_cfg    = mm;
      #1;
      r = route(gc, mm, va, usr);
      check(tag, "tlb_req_valid", tlb_req_valid, (r == 2) ? 1 : 0);
      if (r == 2) begin
         check("R7", "tlb_vaddr", tlb_vaddr, va);
         check("R7", "tlb_acc", tlb_acc, acc);
         check("R7", "tlb_user", tlb_user, usr);
         check("R8", "tlb_sel_insn", tlb_sel_insn, (acc == 2'd2) ? 1 : 0);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      cur_tag   = "R9";
      req_valid = 1'b0;
      req_vaddr = 32'hDEAD_BEEF;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9", "reset rsp_valid", rsp_valid, 0);
      check("R9", "reset rsp_paddr", rsp_paddr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: enable bits singly, together, and unrelated bits only
      req("R1", 32'h5123_4567, 2'd0, 1'b0, 32'hFFFF_FFF3, 32'hFFFF);
      req("R1", 32'h5123_4567, 2'd0, 1'b0, 32'h0000_0008, 32'h0000);
      req("R1", 32'h5123_4567, 2'd0, 1'b0, 32'h0000_0004, 32'h0000);
      req("R1", 32'h5123_4567, 2'd0, 1'b0, 32'h0000_000C, 32'hFFFF);
      idle();
      // R2: translation off, all access types, user and kernel
      req("R2", 32'hA0B0_C0D0, 2'd2, 1'b1, 32'h0, 32'hFFFF);
      req("R2", 32'h0000_0010, 2'd1, 1'b0, 32'h0, 32'h0);
      req("R2", 32'hFFFF_FFFF, 2'd0, 1'b1, 32'h0, 32'h0);
      idle();
      // R3: enabled region vs neighbours with enable clear
      req("R3", 32'h5ABC_DEF0, 2'd0, 1'b0, 32'h4, 32'h0020);
      req("R3", 32'h6ABC_DEF0, 2'd0, 1'b0, 32'h4, 32'h0020);
      req("R3", 32'h4ABC_DEF0, 2'd1, 1'b0, 32'h4, 32'h0020);
      // R4: user request to a direct-mapped region is paged
      req("R4", 32'h5ABC_DE10, 2'd0, 1'b1, 32'h8, 32'h0020);
      req("R4", 32'hF000_0010, 2'd2, 1'b1, 32'h8, 32'hFFFF);
      idle();
      // R5 / R6: region boundaries of both base registers
      req("R6", 32'h0123_4567, 2'd0, 1'b0, 32'h8, 32'hFFFF);
      req("R6", 32'h7FFF_FFFF, 2'd1, 1'b0, 32'h8, 32'hFFFF);
      req("R6", 32'h8000_0000, 2'd2, 1'b0, 32'h8, 32'hFFFF);
      req("R6", 32'hF765_4321, 2'd0, 1'b0, 32'h8, 32'hFFFF);
      req("R5", 32'h3FED_CBA9, 2'd2, 1'b0, 32'hC, 32'h0008);
      req("R5", 32'hBFED_CBA9, 2'd1, 1'b0, 32'hC, 32'h0800);
      idle();
      // R7 / R8: paged reads, writes, executes back to back
      req("R7", 32'h1234_5010, 2'd0, 1'b1, 32'h4, 32'h0);
      req("R8", 32'h1234_5000, 2'd2, 1'b0, 32'h4, 32'h0);
      req("R8", 32'h9876_5430, 2'd1, 1'b1, 32'h4, 32'h0);
      req("R8", 32'h2222_2222, 2'd2, 1'b1, 32'h4, 32'h0);
      idle();
      idle();
      // R9: single request after gap
      req("R9", 32'hC000_1234, 2'd0, 1'b0, 32'h0, 32'h0);
      idle();
      idle();
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog: actual %0d expected %0d", cycles, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule